// File: doc/BRIEF.md
# Two-Row Keypad Scanner

This block reads a small key matrix of two rows and three columns after a single start request. It puts the upper row on the row-select line, waits a settle time, and takes one sample of the three active-low column lines. It then switches to the lower row, waits again, and samples again. The two samples are folded into a six-bit vector of pressed keys. Each column position maps to its own fixed bit, so the mapping does not follow column order.

From the same vector the block derives a recovery flag, raised when one particular three-key combination is held. It also gives a two-bit boot-delay hint. All results are registered and appear together with a single-cycle done strobe. Early boot logic starts one scan and acts on the strobe. The settle time is set in clock cycles from the clock frequency and a time in microseconds.

Top module: `kpad_scan`

## Requirements
- R1: `row_sel_o` is 0 while the upper row is selected and 1 while the lower row is selected. The upper row comes first in every scan, and the line returns to 0 once the scan ends.
- R2: Each row is held for SETTLE_CYC = CLK_HZ/1e6*SETTLE_US clock cycles before it is sampled. `done_o` rises 2*SETTLE_CYC cycles after the clock edge that accepts `start_i`.
- R3: A column input at 0 means the key at that row and column is pressed. A column input at 1 means that key is released.
- R4: Upper-row samples map as follows: column 0 (`cols_ni[0]`) goes to `keys_o[5]`, column 1 goes to `keys_o[3]`, and column 2 goes to `keys_o[4]`.
- R5: Lower-row samples map as follows: column 0 goes to `keys_o[2]`, column 1 goes to `keys_o[1]`, and column 2 goes to `keys_o[0]`.
- R6: Every scan starts from an empty vector, so no key from an earlier scan carries into a new result.
- R7: `recovery_o` is 1 exactly when `keys_o[5]`, `keys_o[3]` and `keys_o[0]` are all set. The state of the other keys does not matter.
- R8: `delay_o` is 0 when recovery is flagged or when no key is pressed. In every other case it is 2.
- R9: `keys_o`, `recovery_o` and `delay_o` change only in the cycle in which `done_o` is high, and `done_o` is high for one cycle per scan. After reset all outputs are 0.
- R10: A `start_i` that arrives while a scan is running is ignored. Such a scan still ends at its original time and produces no second strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Scan request pulse |
| row_sel_o | output | 1 | Row select: 0 selects the upper row, 1 the lower row |
| cols_ni | input | 3 | Active-low column sense lines |
| keys_o | output | 6 | Pressed-key vector |
| recovery_o | output | 1 | Recovery hotkey combination held |
| delay_o | output | 2 | Boot-delay hint (0 or 2) |
| done_o | output | 1 | One-cycle result strobe |

## Verification
The bench models the matrix by presenting a separate column pattern for each level of the row-select line. It sweeps all 64 key combinations, which checks every column-to-bit mapping for both rows. The sweep also covers every input to the recovery and delay decisions: the hotkey triple alone, the triple with extra keys, partial triples, and the empty vector. Dedicated runs check three further behaviours. An all-pressed scan followed by an empty scan shows that the vector is cleared. A start request in the middle of a scan shows that the block does not restart. Changing the keys while idle shows that the outputs hold.

// File: rtl/kpad_pkg.sv
package kpad_pkg;
  localparam int unsigned KEY_W = 6;
  localparam int unsigned COL_N = 3;
  localparam int unsigned DLY_W = 2;

  localparam logic [KEY_W-1:0] REC_MASK = 6'b101001;
  localparam logic [DLY_W-1:0] DLY_HOLD = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_UP   = 2'd1,
    ST_LO   = 2'd2
  } scan_st_e;
endpackage

// File: rtl/kpad_settle_tmr.sv
module kpad_settle_tmr #(
  parameter int unsigned CYC = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (load_i) cnt_q <= CNT_TOP;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  a_r2_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_TOP);
  a_r2_load_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == CNT_TOP));
endmodule

// File: rtl/kpad_col_map.sv
module kpad_col_map
  import kpad_pkg::*;
(
  input  logic             row_i,
  input  logic [COL_N-1:0] cols_ni,
  output logic [KEY_W-1:0] hits_o
);
  localparam int unsigned UP_BIT [COL_N] = '{5, 3, 4};
  localparam int unsigned LO_BIT [COL_N] = '{2, 1, 0};

  always_comb begin
    hits_o = '0;
    for (int c = 0; c < COL_N; c++) begin
      if (!cols_ni[c]) begin
        if (row_i) hits_o[LO_BIT[c]] = 1'b1;
        else       hits_o[UP_BIT[c]] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/kpad_hotkey.sv
module kpad_hotkey
  import kpad_pkg::*;
(
  input  logic [KEY_W-1:0] keys_i,
  output logic             rec_o,
  output logic [DLY_W-1:0] dly_o
);
  assign rec_o = ((keys_i & REC_MASK) == REC_MASK);
  assign dly_o = (rec_o || keys_i == '0) ? '0 : DLY_HOLD;

  always_comb begin
    a_r8_rec_no_delay: assert (!rec_o || dly_o == '0);
  end
endmodule

// File: rtl/kpad_scan.sv
module kpad_scan
  import kpad_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 200_000_000,
  parameter int unsigned SETTLE_US = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             row_sel_o,
  input  logic [COL_N-1:0] cols_ni,
  output logic [KEY_W-1:0] keys_o,
  output logic             recovery_o,
  output logic [DLY_W-1:0] delay_o,
  output logic             done_o
);
  localparam int unsigned SETTLE_CYC_RAW = (CLK_HZ / 1_000_000) * SETTLE_US;
  localparam int unsigned SETTLE_CYC = (SETTLE_CYC_RAW > 0) ? SETTLE_CYC_RAW : 1;

  scan_st_e         st_q;
  logic             row_q;
  logic [KEY_W-1:0] acc_q;
  logic [KEY_W-1:0] hits;
  logic [KEY_W-1:0] final_keys;
  logic             expired;
  logic             load;
  logic             rec_c;
  logic [DLY_W-1:0] dly_c;

  assign load = (st_q == ST_IDLE && start_i) || (st_q == ST_UP && expired);

  kpad_settle_tmr #(.CYC(SETTLE_CYC)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .expired_o (expired)
  );

  kpad_col_map u_map (
    .row_i   (row_q),
    .cols_ni (cols_ni),
    .hits_o  (hits)
  );

  assign final_keys = acc_q | hits;

  kpad_hotkey u_hot (
    .keys_i (final_keys),
    .rec_o  (rec_c),
    .dly_o  (dly_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      row_q      <= 1'b0;
      acc_q      <= '0;
      keys_o     <= '0;
      recovery_o <= 1'b0;
      delay_o    <= '0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_UP;
          row_q <= 1'b0;
          acc_q <= '0;
        end
        ST_UP: if (expired) begin
          acc_q <= final_keys;
          row_q <= 1'b1;
          st_q  <= ST_LO;
        end
        ST_LO: if (expired) begin
          keys_o     <= final_keys;
          recovery_o <= rec_c;
          delay_o    <= dly_c;
          done_o     <= 1'b1;
          row_q      <= 1'b0;
          st_q       <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign row_sel_o = row_q;

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_keys_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(keys_o) && $stable(recovery_o) && $stable(delay_o)));
  a_r1_row_lower: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LO) |-> row_sel_o);
  a_r1_row_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> !row_sel_o);
  a_r10_busy_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_UP && start_i) |=> (st_q != ST_IDLE));
  a_r8_rec_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recovery_o |-> (delay_o == '0));
endmodule

// File: tb/kpad_scan_tb_top.sv
`timescale 1ns/1ps
module kpad_scan_tb_top;
  localparam int unsigned CLK_HZ = 1_000_000;
  localparam int unsigned SETTLE_US = 10;
  localparam int unsigned N = (CLK_HZ / 1_000_000) * SETTLE_US;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start = 1'b0;
  logic       row_sel;
  logic [2:0] cols_n;
  logic [5:0] keys;
  logic       rec;
  logic [1:0] dly;
  logic       done;

  logic [2:0] up_n = 3'b111;
  logic [2:0] lo_n = 3'b111;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  assign cols_n = row_sel ? lo_n : up_n;

  kpad_scan #(.CLK_HZ(CLK_HZ), .SETTLE_US(SETTLE_US)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .row_sel_o(row_sel),
    .cols_ni(cols_n), .keys_o(keys), .recovery_o(rec), .delay_o(dly), .done_o(done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R3/R4/R5: press vector p -> active-low columns per row
  task automatic set_keys(input logic [5:0] p);
    up_n = ~{p[4], p[3], p[5]};
    lo_n = ~{p[0], p[1], p[2]};
  endtask

  task automatic run_scan(input int mid_start, output int lat, output int row_err);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    lat = 0; row_err = 0;
    while (!done && lat < 4 * N) begin
      if (row_sel != (lat >= int'(N))) row_err++;
      if (lat == mid_start) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    if (row_sel) row_err++;
  endtask

  initial begin
    int lat, rerr, dn;
    logic [5:0] prev;
    #12; rst_ni = 1'b1;
    @(negedge clk);
    check("R9 reset keys", keys, 0);
    check("R9 reset flags", {rec, dly, done}, 0);
    check("R1 reset row", row_sel, 0);

    for (int p = 0; p < 64; p++) begin
      logic [5:0] pv;
      int er, ed;
      pv = 6'(p);
      set_keys(pv);
      run_scan(-1, lat, rerr);
      er = (pv[5] & pv[3] & pv[0]) ? 1 : 0;
      ed = (er == 1 || pv == 0) ? 0 : 2;
      check("R3 R4 R5 keys", keys, p);
      check("R7 recovery", rec, er);
      check("R8 delay", dly, ed);
      check("R2 latency", lat, 2 * N);
      check("R1 row order", rerr, 0);
      @(negedge clk);
      check("R9 single strobe", done, 0);
    end

    // R6: all pressed, then none
    set_keys(6'h3f); run_scan(-1, lat, rerr);
    check("R6 full", keys, 63);
    set_keys(6'h00); run_scan(-1, lat, rerr);
    check("R6 cleared", keys, 0);
    check("R8 none pressed", dly, 0);

    // R9: outputs hold while idle despite key changes
    set_keys(6'h29); run_scan(-1, lat, rerr);
    prev = keys;
    set_keys(6'h12);
    dn = 0;
    for (int i = 0; i < 3 * N; i++) begin
      @(negedge clk);
      if (done) dn++;
    end
    check("R9 hold keys", keys, int'(prev));
    check("R9 hold rec", rec, 1);
    check("R9 no strobe idle", dn, 0);

    // R10: start mid-scan ignored
    set_keys(6'h04);
    run_scan(N / 2, lat, rerr);
    check("R10 latency", lat, 2 * N);
    check("R10 keys", keys, 4);
    dn = 0;
    for (int i = 0; i < 3 * N; i++) begin
      @(negedge clk);
      if (done) dn++;
    end
    check("R10 no restart", dn, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule